// File: doc/BRIEF.md
# Remote Write Bus Arbiter

This block arbitrates a shared memory bus between a local processor and an external remote processor. The remote side writes into the local address space through this block. A remote write request is the logical AND of an access-enable line and a write strobe. As soon as that request appears, the block pulls its ready line low to stall the remote side. It then waits until the local side has no bus request pending, and only then takes the bus. Once it owns the bus, it tri-states the local address drivers and steers the write to one of several targets.

The target is chosen from a command bit and a two-bit memory select. The possible targets are a control register, either byte of the program counter, data memory, or instruction memory. Instruction memory is written in two passes. The first pass loads the low byte into a holding latch. The second pass commits the full word and requests a program-counter increment. Data-memory and instruction-memory writes each stretch by their own programmed wait count, and every access also waits for an external ready input. When the write completes, the ready line returns high for one cycle while the remote side still owns the bus. The bus then goes back to the local side. If the remote request is still present, the block parks until the request drops.

A lock-out input keeps the block idle for as long as it is set. The local side keeps the bus during that time.

Top module: `rwr_arbiter`

## Requirements
- R1: After reset the block is idle with `xfer_rdy`=1, `bus_remote`=0, `bus_hiz`=0, and all write strobes low. The instruction byte tracker is cleared, so the next instruction write goes to the holding latch.
- R2: While idle, `lcl_grant` follows `lcl_req` in the same cycle and `lcl_stall` stays 0.
- R3: While idle, `xfer_rdy` drops in the same cycle that `rem_en` and `rem_wr` are both high, even when `lcl_req` is high.
- R4: The block leaves idle only when the request is present, `lcl_req` is 0 and `lock_out` is 0. While `lock_out` or `lcl_req` is high, `bus_remote` stays 0 indefinitely.
- R5: From the cycle after leaving idle until the termination cycle, `lcl_grant` is 0 and `lcl_stall` equals `lcl_req`.
- R6: Two cycles after the request is accepted, `bus_remote` and `bus_hiz` go to 1 and `xfer_rdy` stays 0.
- R7: Dispatch works as follows. `cmd_sel`=1 pulses `we_ctrl`. With `cmd_sel`=0, `mem_sel`=2'b10 pulses `we_pc_lo`, 2'b11 pulses `we_pc_hi`, 2'b00 raises `mem_we`, and 2'b01 takes the instruction path. At most one strobe is high at a time.
- R8: `mem_we` stays high for `dwait_cfg`+1 cycles when `ext_ready` is high.
- R9: Instruction writes alternate. The first raises `we_ilat` and the second raises `we_imem`, each for `iwait_cfg`+1 cycles. `pc_inc` pulses in the release cycle after a `we_imem` access.
- R10: While `ext_ready` is 0, the active strobe holds and the access does not end.
- R11: After the access, one termination cycle has `xfer_rdy`=1 and `bus_remote`=1. In the next cycle `bus_remote`=0 and `lcl_grant` follows `lcl_req` again.
- R12: If the request is still high after release, the block holds with `xfer_rdy`=1, `bus_remote`=0 and no strobe until the request drops, then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rem_en | input | 1 | Remote access enable |
| rem_wr | input | 1 | Remote write strobe |
| cmd_sel | input | 1 | 1 = control register target |
| mem_sel | input | 2 | Memory select (00 data, 01 instruction, 10 PC low, 11 PC high) |
| lock_out | input | 1 | Holds the block idle |
| lcl_req | input | 1 | Local bus request |
| iwait_cfg | input | IW_W | Instruction-memory wait states |
| dwait_cfg | input | DW_W | Data-memory wait states |
| ext_ready | input | 1 | External ready; 0 extends the access |
| xfer_rdy | output | 1 | Ready to remote side, low while the write is pending |
| bus_remote | output | 1 | Remote side owns the memory buses |
| bus_hiz | output | 1 | Local address drivers tri-stated |
| mem_we | output | 1 | Data-memory write strobe |
| lcl_grant | output | 1 | Local bus grant |
| lcl_stall | output | 1 | Local data access stalled |
| we_ctrl | output | 1 | Control register write |
| we_pc_lo | output | 1 | PC low byte write |
| we_pc_hi | output | 1 | PC high byte write |
| we_ilat | output | 1 | Instruction low-byte latch write |
| we_imem | output | 1 | Instruction memory word write |
| pc_inc | output | 1 | PC increment pulse |

## Verification
The hardest situations to reach from the ports are collisions on the request path. One is a remote request that arrives while the local side holds the bus and must be both stalled and kept waiting. Another is a local request that arrives after the takeover has begun. The bench drives these directly: it holds `lcl_req` high across the remote request, then releases it, then raises it again mid-access. It also holds `ext_ready` low past the wait count to stretch an access. Finally, it issues a reset between the two passes of an instruction write, to show that the byte tracker falls back to the latch pass.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLAIM, ST_SETUP, ST_CTRL, ST_PCLO, ST_PCHI,
    ST_DMEM, ST_ILAT, ST_IMEM, ST_TERM, ST_REL, ST_HOLD
  } st_e;

  localparam logic [1:0] MS_DATA = 2'b00;
  localparam logic [1:0] MS_INST = 2'b01;
  localparam logic [1:0] MS_PCLO = 2'b10;
  localparam logic [1:0] MS_PCHI = 2'b11;
endpackage

// File: rtl/rwa_wait_ctr.sv
module rwa_wait_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic         is_zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt_q <= '0;
    else if (load || dec_en)   cnt_q <= cnt_d;

  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/rwa_byte_track.sv
module rwa_byte_track (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic high_next
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      high_next <= 1'b0;
    else if (toggle) high_next <= ~high_next;
endmodule

// File: rtl/rwa_next.sv
module rwa_next
  import rwa_pkg::*;
(
  input  st_e        st,
  input  logic       req,
  input  logic       lock_out,
  input  logic       lcl_req,
  input  logic       cmd_sel,
  input  logic [1:0] mem_sel,
  input  logic       high_next,
  input  logic       dzero,
  input  logic       izero,
  input  logic       ready,
  output st_e        nxt
);
  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (req && !lock_out && !lcl_req) nxt = ST_CLAIM;
      ST_CLAIM: nxt = ST_SETUP;
      ST_SETUP: begin
        if (cmd_sel) nxt = ST_CTRL;
        else begin
          unique case (mem_sel)
            MS_PCLO: nxt = ST_PCLO;
            MS_PCHI: nxt = ST_PCHI;
            MS_DATA: nxt = ST_DMEM;
            default: nxt = high_next ? ST_IMEM : ST_ILAT;
          endcase
        end
      end
      ST_CTRL, ST_PCLO, ST_PCHI: if (ready) nxt = ST_TERM;
      ST_DMEM:           if (dzero && ready) nxt = ST_TERM;
      ST_ILAT, ST_IMEM:  if (izero && ready) nxt = ST_TERM;
      ST_TERM:  nxt = ST_REL;
      ST_REL:   nxt = req ? ST_HOLD : ST_IDLE;
      ST_HOLD:  if (!req) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rwr_arbiter.sv
module rwr_arbiter
  import rwa_pkg::*;
#(
  parameter int IW_W = 2,
  parameter int DW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rem_en,
  input  logic            rem_wr,
  input  logic            cmd_sel,
  input  logic [1:0]      mem_sel,
  input  logic            lock_out,
  input  logic            lcl_req,
  input  logic [IW_W-1:0] iwait_cfg,
  input  logic [DW_W-1:0] dwait_cfg,
  input  logic            ext_ready,
  output logic            xfer_rdy,
  output logic            bus_remote,
  output logic            bus_hiz,
  output logic            mem_we,
  output logic            lcl_grant,
  output logic            lcl_stall,
  output logic            we_ctrl,
  output logic            we_pc_lo,
  output logic            we_pc_hi,
  output logic            we_ilat,
  output logic            we_imem,
  output logic            pc_inc
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  assign rst_int_n = rsync_q[1];

  st_e  st_q, st_d;
  st_e  acc_q;
  logic req, high_next, dzero, izero;
  logic in_access, leave_access, owned;

  assign req = rem_en & rem_wr;

  rwa_next u_next (
    .st(st_q), .req(req), .lock_out(lock_out), .lcl_req(lcl_req),
    .cmd_sel(cmd_sel), .mem_sel(mem_sel), .high_next(high_next),
    .dzero(dzero), .izero(izero), .ready(ext_ready), .nxt(st_d)
  );

  rwa_wait_ctr #(.W(DW_W)) u_dwait (
    .clk(clk), .rst_n(rst_int_n), .load(st_q == ST_SETUP),
    .load_val(dwait_cfg), .dec_en(st_q == ST_DMEM && !dzero), .is_zero(dzero)
  );

  rwa_wait_ctr #(.W(IW_W)) u_iwait (
    .clk(clk), .rst_n(rst_int_n), .load(st_q == ST_SETUP),
    .load_val(iwait_cfg),
    .dec_en((st_q == ST_ILAT || st_q == ST_IMEM) && !izero), .is_zero(izero)
  );

  rwa_byte_track u_hib (
    .clk(clk), .rst_n(rst_int_n),
    .toggle(st_q == ST_REL && (acc_q == ST_ILAT || acc_q == ST_IMEM)),
    .high_next(high_next)
  );

  always_ff @(posedge clk or negedge rst_int_n)
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;

  assign in_access = (st_q inside {ST_CTRL, ST_PCLO, ST_PCHI, ST_DMEM, ST_ILAT, ST_IMEM});
  assign leave_access = in_access && (st_d == ST_TERM);

  always_ff @(posedge clk or negedge rst_int_n)
    if (!rst_int_n)        acc_q <= ST_IDLE;
    else if (leave_access) acc_q <= st_q;

  assign owned = in_access || st_q == ST_SETUP || st_q == ST_TERM;

  always_comb begin
    unique case (st_q)
      ST_IDLE:                 xfer_rdy = ~req;
      ST_TERM, ST_REL, ST_HOLD: xfer_rdy = 1'b1;
      default:                 xfer_rdy = 1'b0;
    endcase
  end

  assign bus_remote = owned;
  assign bus_hiz    = owned;
  assign lcl_grant  = lcl_req && (st_q == ST_IDLE || st_q == ST_REL || st_q == ST_HOLD);
  assign lcl_stall  = lcl_req && (owned || st_q == ST_CLAIM);
  assign we_ctrl    = (st_q == ST_CTRL);
  assign we_pc_lo   = (st_q == ST_PCLO);
  assign we_pc_hi   = (st_q == ST_PCHI);
  assign mem_we     = (st_q == ST_DMEM);
  assign we_ilat    = (st_q == ST_ILAT);
  assign we_imem    = (st_q == ST_IMEM);
  assign pc_inc     = (st_q == ST_REL) && (acc_q == ST_IMEM);
endmodule

// File: rtl/rwa_chk.sv
module rwa_chk
  import rwa_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input st_e        st,
  input logic       lock_out,
  input logic       ext_ready,
  input logic       xfer_rdy,
  input logic       bus_remote,
  input logic       bus_hiz,
  input logic       lcl_grant,
  input logic [5:0] strb
);
  assert_no_grant_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_remote |-> !lcl_grant);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  assert_strobe_on_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb) |-> (bus_remote && bus_hiz));

  assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && lock_out) |=> (st != ST_CLAIM));

  assert_wait_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strb) && !ext_ready) |=> (strb == $past(strb)));

  assert_ready_before_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_remote) |-> $past(xfer_rdy));

  assert_hold_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (xfer_rdy && !bus_remote));
endmodule

bind rwr_arbiter rwa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .lock_out(lock_out),
  .ext_ready(ext_ready), .xfer_rdy(xfer_rdy), .bus_remote(bus_remote),
  .bus_hiz(bus_hiz), .lcl_grant(lcl_grant),
  .strb({we_ctrl, we_pc_lo, we_pc_hi, mem_we, we_ilat, we_imem})
);

// File: tb/tb_rwr_arbiter.sv
module tb_rwr_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic rem_en, rem_wr, cmd_sel, lock_out, lcl_req, ext_ready;
  logic [1:0] mem_sel;
  logic [1:0] iwait_cfg;
  logic [2:0] dwait_cfg;
  logic xfer_rdy, bus_remote, bus_hiz, mem_we, lcl_grant, lcl_stall;
  logic we_ctrl, we_pc_lo, we_pc_hi, we_ilat, we_imem, pc_inc;
  logic [5:0] strobes;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rwr_arbiter dut (.*);

  // strobe bits: [5]ctrl [4]pc_lo [3]pc_hi [2]dmem [1]ilat [0]imem
  assign strobes = {we_ctrl, we_pc_lo, we_pc_hi, mem_we, we_ilat, we_imem};

  typedef struct packed {
    logic       cmd;
    logic [1:0] ms;
    logic [2:0] dw;
    logic [1:0] iw;
    logic [5:0] mask;
    logic [3:0] rdylo;
    logic [3:0] hold;
  } vec_t;

  localparam vec_t TBL [0:11] = '{
    {1'b1, 2'b00, 3'd3, 2'd1, 6'b100000, 4'd0, 4'd0},
    {1'b0, 2'b10, 3'd0, 2'd0, 6'b010000, 4'd0, 4'd0},
    {1'b0, 2'b11, 3'd2, 2'd2, 6'b001000, 4'd0, 4'd0},
    {1'b0, 2'b00, 3'd0, 2'd3, 6'b000100, 4'd0, 4'd0},
    {1'b0, 2'b00, 3'd5, 2'd0, 6'b000100, 4'd0, 4'd0},
    {1'b0, 2'b01, 3'd1, 2'd2, 6'b000010, 4'd0, 4'd0},
    {1'b0, 2'b01, 3'd4, 2'd0, 6'b000001, 4'd0, 4'd0},
    {1'b0, 2'b01, 3'd0, 2'd3, 6'b000010, 4'd0, 4'd0},
    {1'b0, 2'b01, 3'd0, 2'd1, 6'b000001, 4'd0, 4'd4},
    {1'b1, 2'b01, 3'd0, 2'd0, 6'b100000, 4'd6, 4'd0},
    {1'b0, 2'b00, 3'd7, 2'd0, 6'b000100, 4'd0, 4'd0},
    {1'b0, 2'b00, 3'd1, 2'd0, 6'b000100, 4'd9, 4'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_txn(input vec_t v);
    int base, acc_len, n, lows, strb_cyc;
    base = (v.mask == 6'b000100) ? int'(v.dw) + 1 :
           (v.mask == 6'b000010 || v.mask == 6'b000001) ? int'(v.iw) + 1 : 1;
    acc_len = (base > int'(v.rdylo) - 2) ? base : int'(v.rdylo) - 2;
    @(negedge clk);
    cmd_sel = v.cmd; mem_sel = v.ms; dwait_cfg = v.dw; iwait_cfg = v.iw;
    rem_en = 1'b1; rem_wr = 1'b1;
    ext_ready = (v.rdylo > 0) ? 1'b0 : 1'b1;
    #1;
    chk(!xfer_rdy, "R3 ack low on request", xfer_rdy, 0);
    n = 0; lows = 0; strb_cyc = 0;
    while (!xfer_rdy && n < 100) begin
      lows++;
      if (n == 2) chk(bus_remote && bus_hiz, "R6 takeover", bus_remote, 1);
      if ((strobes & ~v.mask) != 0) chk(0, "R7 wrong strobe", strobes, v.mask);
      if (strobes != 0) strb_cyc++;
      @(negedge clk);
      n++;
      ext_ready = (n < int'(v.rdylo)) ? 1'b0 : 1'b1;
      #1;
    end
    chk(strb_cyc == acc_len, "R8 R9 R10 strobe length", strb_cyc, acc_len);
    chk(lows == 3 + acc_len, "R7 ack low span", lows, 3 + acc_len);
    chk(bus_remote && strobes == 0, "R11 termination", bus_remote, 1);
    @(negedge clk);
    if (v.hold == 0) rem_wr = 1'b0;
    #1;
    chk(!bus_remote && xfer_rdy, "R11 release", bus_remote, 0);
    chk(pc_inc == (v.mask == 6'b000001), "R9 pc_inc", pc_inc, v.mask == 6'b000001);
    if (v.hold != 0) begin
      for (int k = 0; k < int'(v.hold); k++) begin
        tick();
        chk(xfer_rdy && !bus_remote && strobes == 0, "R12 hold", bus_remote, 0);
      end
      @(negedge clk);
      rem_wr = 1'b0;
      #1;
    end
    tick();
    chk(xfer_rdy && !bus_remote, "R12 back to idle", bus_remote, 0);
    rem_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rem_en = 0; rem_wr = 0; cmd_sel = 0; mem_sel = 0;
    lock_out = 0; lcl_req = 0; ext_ready = 1; iwait_cfg = 0; dwait_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(xfer_rdy && !bus_remote && !bus_hiz && strobes == 0, "R1 reset", strobes, 0);

    // table walk
    for (int i = 0; i < 12; i++) run_txn(TBL[i]);

    // R2 local grant in idle
    @(negedge clk); lcl_req = 1'b1; #1;
    chk(lcl_grant && !lcl_stall, "R2 idle grant", lcl_grant, 1);
    // R3 request while local request pending
    @(negedge clk); rem_en = 1; rem_wr = 1; cmd_sel = 1; #1;
    chk(!xfer_rdy && lcl_grant, "R3 ack low under local", xfer_rdy, 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(!bus_remote && lcl_grant, "R4 wait for local idle", bus_remote, 0);
    end
    @(negedge clk); lcl_req = 1'b0; #1;
    @(negedge clk); lcl_req = 1'b1; #1;   // claim cycle
    chk(!lcl_grant && lcl_stall, "R5 stall in claim", lcl_stall, 1);
    tick();
    chk(bus_remote && lcl_stall && !lcl_grant, "R5 R6 setup", bus_remote, 1);
    tick();
    chk(we_ctrl && !lcl_grant, "R7 ctrl write", we_ctrl, 1);
    tick();
    chk(xfer_rdy && bus_remote && lcl_stall, "R11 term stall", lcl_stall, 1);
    @(negedge clk); rem_wr = 0; #1;
    chk(lcl_grant && !lcl_stall && !bus_remote, "R11 grant after release", lcl_grant, 1);
    @(negedge clk); lcl_req = 0; rem_en = 0; cmd_sel = 0; #1;

    // R4 lock-out
    @(negedge clk); lock_out = 1; rem_en = 1; rem_wr = 1; #1;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(!bus_remote && strobes == 0, "R4 lock-out idle", bus_remote, 0);
    end
    @(negedge clk); lock_out = 0; rem_wr = 0; rem_en = 0; #1;
    tick();

    // R1 reset clears instruction byte tracker
    run_txn({1'b0, 2'b01, 3'd0, 2'd0, 6'b000010, 4'd0, 4'd0});
    @(negedge clk); rst_n = 1'b0; #1;
    chk(xfer_rdy && !bus_remote && strobes == 0, "R1 async reset", bus_remote, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    run_txn({1'b0, 2'b01, 3'd0, 2'd1, 6'b000010, 4'd0, 4'd0});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule